// File: doc/BRIEF.md
# Message-Signalled Interrupt to LPI Translator

This block takes message-signalled interrupt writes from PCI-style requesters and turns each valid one into a one-cycle request to set a locality-specific peripheral interrupt (LPI) pending at one processor. The requester's bus/device/function number is used as the device number. The full 32-bit message data word is used as the event number. The write address must hit the translation register in the upper of the unit's two 64 KiB frames.

The translation is a walk through three tables in turn: a device table, a shared interrupt translation store, and a collection table. Each table reads in one cycle. A configuration write port loads all three tables. If any check on the way fails (a mapping that is not valid, an index out of range, an ID out of range), the message is silently discarded and no record is kept. While a walk is under way, the unit holds its ready output low, so only one message is in flight at a time.

Top module: `msi_xlate`

## Requirements
- R1: After a synchronous active-low reset, `msi_ready` is 1 and `lpi_valid` is 0.
- R2: A message is discarded with no output pulse when `enable` is 0 in the cycle it is accepted.
- R3: A message is translated only if `msi_addr` equals `BASE_ADDR` + 65536 + `XLATE_OFS`. Any other address, including the same offset in the lower frame, is discarded.
- R4: `msi_rid` indexes the device table. A value at or above `DEV_ENTRIES` (256) is discarded.
- R5: A device entry holds a valid flag at bit 23. If the flag is clear, the message is discarded.
- R6: A device entry holds a size field in bits 22:16. An event number at or above 2^(size+1) is discarded.
- R7: The translation entry read is at index (device entry bits 15:0 + event number) modulo `ITT_DEPTH` (1024).
- R8: A translation entry holds the interrupt ID in bits 15:0. An ID below 8192 is discarded.
- R9: A translation entry holds the collection number in bits 23:16. A value at or above `NUM_COLL` (16) is discarded.
- R10: A whole 24-bit collection entry is the target CPU number. A value at or above `NUM_CPUS` (8) is discarded.
- R11: On success, `lpi_valid` and `lpi_set` are high for exactly one cycle. This is the fourth rising edge after the accepting edge, where the accepting edge counts as the first edge. In that cycle `lpi_intid` and `lpi_cpu` carry the translated values.
- R12: `msi_ready` is low from the accepting edge until the pulse cycle ends, and high again in the cycle that follows the pulse.
- R13: `cfg_sel` chooses the table to write: 0 for the device table, 1 for the translation store, 2 for the collection table. A write with `cfg_sel` = 3, or with `cfg_addr` at or beyond the depth of the selected table, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global translation enable |
| msi_valid | input | 1 | Message write present |
| msi_ready | output | 1 | Unit idle, can accept a message |
| msi_addr | input | 32 | Message write address |
| msi_data | input | 32 | Message data (event number) |
| msi_rid | input | 16 | Requester bus/device/function (device number) |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select |
| cfg_addr | input | 16 | Table entry index |
| cfg_wdata | input | 24 | Table entry value |
| lpi_valid | output | 1 | One-cycle set-pending request |
| lpi_set | output | 1 | Asserted flag of the request |
| lpi_intid | output | 16 | Interrupt ID to set pending |
| lpi_cpu | output | 3 | Target CPU number |

## Verification
The tables are filled at random, with roughly one device in four unmapped, one interrupt ID in five below the LPI range, and collection and CPU values that sometimes run past their limits. Random messages then reach every drop point as well as success, and a bench model predicts whether each one leads to a pulse.

Directed messages sit exactly on each boundary so that an off-by-one in a single check shows up on its own:
- event number equal to the table size, and one below it;
- interrupt ID 8191 and 8192;
- collection number 15 and 16;
- CPU number 7 and 8;
- device number 256;
- an address in the lower frame.

Further directed cases prove that a disabled unit, a `cfg_sel` of 3 and an out-of-range configuration index leave everything unchanged. The exact pulse cycle and the ready pattern separate a correct walk from one with a stage too many or too few.

// File: rtl/msi_xlate_pkg.sv
// Shared constants and types for the message-to-LPI translator.
// Assumes every table entry is one ENTRY_W-bit word with fixed field places.
package msi_xlate_pkg;

    localparam int ENTRY_W     = 24;
    localparam int FRAME_BYTES = 65536;

    // Device table entry fields
    localparam int DTE_BASE_LO = 0;
    localparam int DTE_BASE_HI = 15;
    localparam int DTE_SIZE_LO = 16;
    localparam int DTE_SIZE_HI = 22;
    localparam int DTE_VALID   = 23;

    // Translation entry fields
    localparam int ITE_ID_LO   = 0;
    localparam int ITE_ID_HI   = 15;
    localparam int ITE_COL_LO  = 16;
    localparam int ITE_COL_HI  = 23;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DTE,
        ST_ITE,
        ST_CTE,
        ST_ISSUE
    } walk_state_t;

endpackage

// File: rtl/xlt_table_ram.sv
// Single-port-write, single-port-read table store with a registered read.
// Assumes the caller presents the read index one cycle before it needs the data.
module xlt_table_ram #(
    parameter int W     = 24,
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Write the addressed entry and register the read word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/xlt_walk.sv
// Table-walk sequencer: accepts a message, reads the device, translation and
// collection entries in turn, and drops the message on the first failed check.
// Assumes each table returns its data one cycle after the read index.
module xlt_walk
    import msi_xlate_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter logic [31:0]     BASE_ADDR   = 32'h0800_0000,
    parameter logic [15:0]     XLATE_OFS   = 16'h0040,
    parameter int              DEV_ENTRIES = 256,
    parameter int              ITT_DEPTH   = 1024,
    parameter int              NUM_COLL    = 16,
    parameter int              NUM_CPUS    = 8,
    parameter int              LPI_BASE    = 8192,
    localparam int             DT_AW       = $clog2(DEV_ENTRIES),
    localparam int             ITT_AW      = $clog2(ITT_DEPTH),
    localparam int             CT_AW       = $clog2(NUM_COLL),
    localparam int             CPU_W       = $clog2(NUM_CPUS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               msi_valid,
    output logic               msi_ready,
    input  logic [ADDR_W-1:0]  msi_addr,
    input  logic [31:0]        msi_data,
    input  logic [15:0]        msi_rid,
    output logic [DT_AW-1:0]   dt_raddr,
    input  logic [ENTRY_W-1:0] dt_rdata,
    output logic [ITT_AW-1:0]  itt_raddr,
    input  logic [ENTRY_W-1:0] itt_rdata,
    output logic [CT_AW-1:0]   ct_raddr,
    input  logic [ENTRY_W-1:0] ct_rdata,
    output logic               lpi_valid,
    output logic [15:0]        lpi_intid,
    output logic [CPU_W-1:0]   lpi_cpu
);

    localparam logic [ADDR_W-1:0] HIT_ADDR =
        ADDR_W'(BASE_ADDR) + ADDR_W'(FRAME_BYTES) + ADDR_W'(XLATE_OFS);

    walk_state_t        state_q, state_d;
    logic [31:0]        event_q;
    logic [15:0]        intid_q;
    logic [CPU_W-1:0]   cpu_q;

    logic               take;
    logic               entry_ok;
    logic               dte_ok;
    logic               ite_ok;
    logic               cte_ok;
    logic [6:0]         dte_size;
    logic [15:0]        dte_base;
    logic [15:0]        ite_id;
    logic [7:0]         ite_col;

    // Field extraction from the table read words.
    always_comb begin
        dte_size = dt_rdata[DTE_SIZE_HI:DTE_SIZE_LO];
        dte_base = dt_rdata[DTE_BASE_HI:DTE_BASE_LO];
        ite_id   = itt_rdata[ITE_ID_HI:ITE_ID_LO];
        ite_col  = itt_rdata[ITE_COL_HI:ITE_COL_LO];
    end

    // Per-stage validity checks.
    always_comb begin
        take     = msi_valid && (state_q == ST_IDLE);
        entry_ok = enable && (msi_addr == HIT_ADDR) && (32'(msi_rid) < DEV_ENTRIES);
        dte_ok   = dt_rdata[DTE_VALID]
                   && ((33'(event_q) >> (8'(dte_size) + 8'd1)) == '0);
        ite_ok   = (32'(ite_id) >= LPI_BASE) && (32'(ite_col) < NUM_COLL);
        cte_ok   = (32'(ct_rdata) < NUM_CPUS);
    end

    // Read indices presented to the tables one cycle ahead of use.
    always_comb begin
        dt_raddr  = msi_rid[DT_AW-1:0];
        itt_raddr = ITT_AW'(32'(dte_base) + event_q);
        ct_raddr  = ite_col[CT_AW-1:0];
    end

    // Next-state selection for the walk.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take && entry_ok) state_d = ST_DTE;
            ST_DTE:   state_d = dte_ok ? ST_ITE : ST_IDLE;
            ST_ITE:   state_d = ite_ok ? ST_CTE : ST_IDLE;
            ST_CTE:   state_d = cte_ok ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the event number and the translated results along the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_q <= '0;
            intid_q <= '0;
            cpu_q   <= '0;
        end else begin
            if (take) begin
                event_q <= msi_data;
            end
            if (state_q == ST_ITE) begin
                intid_q <= ite_id;
            end
            if (state_q == ST_CTE) begin
                cpu_q <= ct_rdata[CPU_W-1:0];
            end
        end
    end

    assign msi_ready = (state_q == ST_IDLE);
    assign lpi_valid = (state_q == ST_ISSUE);
    assign lpi_intid = intid_q;
    assign lpi_cpu   = cpu_q;

    // R11
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_valid |=> !lpi_valid);

    // R12
    ready_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_valid |=> msi_ready);

    // R2
    disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && msi_ready && !enable) |=> (msi_ready && !lpi_valid));

    // R3
    address_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && msi_ready && (msi_addr != HIT_ADDR)) |=> msi_ready);

    // R8
    lpi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_valid |-> (32'(lpi_intid) >= LPI_BASE));

    // R12
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && entry_ok) |=> !msi_ready);

endmodule

// File: rtl/msi_xlate.sv
// Top of the message-to-LPI translator: configuration decode, the three
// table stores and the walk sequencer.
// Assumes configuration writes are made while no message is in flight.
module msi_xlate
    import msi_xlate_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] BASE_ADDR   = 32'h0800_0000,
    parameter logic [15:0] XLATE_OFS   = 16'h0040,
    parameter int          DEV_ENTRIES = 256,
    parameter int          ITT_DEPTH   = 1024,
    parameter int          NUM_COLL    = 16,
    parameter int          NUM_CPUS    = 8,
    parameter int          LPI_BASE    = 8192,
    localparam int         DT_AW       = $clog2(DEV_ENTRIES),
    localparam int         ITT_AW      = $clog2(ITT_DEPTH),
    localparam int         CT_AW       = $clog2(NUM_COLL),
    localparam int         CPU_W       = $clog2(NUM_CPUS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               msi_valid,
    output logic               msi_ready,
    input  logic [ADDR_W-1:0]  msi_addr,
    input  logic [31:0]        msi_data,
    input  logic [15:0]        msi_rid,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [15:0]        cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    output logic               lpi_valid,
    output logic               lpi_set,
    output logic [15:0]        lpi_intid,
    output logic [CPU_W-1:0]   lpi_cpu
);

    logic                dt_we, itt_we, ct_we;
    logic [DT_AW-1:0]    dt_raddr;
    logic [ITT_AW-1:0]   itt_raddr;
    logic [CT_AW-1:0]    ct_raddr;
    logic [ENTRY_W-1:0]  dt_rdata, itt_rdata, ct_rdata;

    // Decode configuration writes; indices past a table's depth are ignored.
    always_comb begin
        dt_we  = cfg_we && (cfg_sel == 2'd0) && (32'(cfg_addr) < DEV_ENTRIES);
        itt_we = cfg_we && (cfg_sel == 2'd1) && (32'(cfg_addr) < ITT_DEPTH);
        ct_we  = cfg_we && (cfg_sel == 2'd2) && (32'(cfg_addr) < NUM_COLL);
    end

    xlt_table_ram #(.W(ENTRY_W), .DEPTH(DEV_ENTRIES)) u_dev_tbl (
        .clk   (clk),
        .we    (dt_we),
        .waddr (cfg_addr[DT_AW-1:0]),
        .wdata (cfg_wdata),
        .raddr (dt_raddr),
        .rdata (dt_rdata)
    );

    xlt_table_ram #(.W(ENTRY_W), .DEPTH(ITT_DEPTH)) u_itt_tbl (
        .clk   (clk),
        .we    (itt_we),
        .waddr (cfg_addr[ITT_AW-1:0]),
        .wdata (cfg_wdata),
        .raddr (itt_raddr),
        .rdata (itt_rdata)
    );

    xlt_table_ram #(.W(ENTRY_W), .DEPTH(NUM_COLL)) u_col_tbl (
        .clk   (clk),
        .we    (ct_we),
        .waddr (cfg_addr[CT_AW-1:0]),
        .wdata (cfg_wdata),
        .raddr (ct_raddr),
        .rdata (ct_rdata)
    );

    xlt_walk #(
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR),
        .XLATE_OFS   (XLATE_OFS),
        .DEV_ENTRIES (DEV_ENTRIES),
        .ITT_DEPTH   (ITT_DEPTH),
        .NUM_COLL    (NUM_COLL),
        .NUM_CPUS    (NUM_CPUS),
        .LPI_BASE    (LPI_BASE)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .msi_valid (msi_valid),
        .msi_ready (msi_ready),
        .msi_addr  (msi_addr),
        .msi_data  (msi_data),
        .msi_rid   (msi_rid),
        .dt_raddr  (dt_raddr),
        .dt_rdata  (dt_rdata),
        .itt_raddr (itt_raddr),
        .itt_rdata (itt_rdata),
        .ct_raddr  (ct_raddr),
        .ct_rdata  (ct_rdata),
        .lpi_valid (lpi_valid),
        .lpi_intid (lpi_intid),
        .lpi_cpu   (lpi_cpu)
    );

    // A message write always asks for the pending bit to be set.
    assign lpi_set = lpi_valid;

    // R13
    cfg_one_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dt_we, itt_we, ct_we}) <= 1);

endmodule

// File: tb/msi_xlate_test.sv
module msi_xlate_test;

    localparam logic [31:0] BASE = 32'h0800_0000;
    localparam logic [31:0] OFS  = 32'h0000_0040;
    localparam logic [31:0] GOOD = BASE + 32'h0001_0000 + OFS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        msi_valid = 1'b0;
    logic        msi_ready;
    logic [31:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic [15:0] msi_rid = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        lpi_valid, lpi_set;
    logic [15:0] lpi_intid;
    logic [2:0]  lpi_cpu;

    int checks = 0;
    int fails  = 0;

    logic [23:0] dt_m  [256];
    logic [23:0] itt_m [1024];
    logic [23:0] ct_m  [16];

    always #5 clk = ~clk;

    msi_xlate uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .msi_valid(msi_valid), .msi_ready(msi_ready),
        .msi_addr(msi_addr), .msi_data(msi_data), .msi_rid(msi_rid),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .lpi_valid(lpi_valid), .lpi_set(lpi_set), .lpi_intid(lpi_intid), .lpi_cpu(lpi_cpu)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Load a table entry into both the design and the bench model.
    task automatic load(input logic [1:0] sel, input int a, input logic [23:0] d);
        cfg_write(sel, 16'(a), d);
        if (sel == 2'd0) dt_m[a] = d;
        else if (sel == 2'd1) itt_m[a] = d;
        else ct_m[a] = d;
    endtask

    // Expected outcome of one message from the requirements.
    task automatic predict(input logic [15:0] rid, input logic [31:0] addr, input logic [31:0] data,
                           output bit ok, output logic [15:0] id, output logic [2:0] cpu);
        logic [23:0] d, e, c;
        int size;
        longint idx;
        ok = 1'b0; id = '0; cpu = '0;
        if (enable && addr == GOOD && rid < 16'd256) begin
            d = dt_m[rid];
            size = int'(d[22:16]);
            if (d[23] && (size >= 31 || longint'(data) < (64'd1 << (size + 1)))) begin
                idx = (longint'(d[15:0]) + longint'(data)) % 1024;
                e = itt_m[idx];
                if (e[15:0] >= 16'd8192 && e[23:16] < 8'd16) begin
                    c = ct_m[e[19:16]];
                    if (c < 24'd8) begin
                        ok = 1'b1; id = e[15:0]; cpu = c[2:0];
                    end
                end
            end
        end
    endtask

    task automatic send(input logic [15:0] rid, input logic [31:0] addr, input logic [31:0] data,
                        input string req);
        bit ok;
        logic [15:0] eid, gid;
        logic [2:0] ecpu, gcpu;
        int pulses, pk;
        bit gset, rdy4, rdy5;
        predict(rid, addr, data, ok, eid, ecpu);
        @(negedge clk);
        while (!msi_ready) @(negedge clk);
        msi_valid = 1'b1; msi_rid = rid; msi_addr = addr; msi_data = data;
        @(negedge clk);
        msi_valid = 1'b0;
        pulses = 0; pk = 0; gid = '0; gcpu = '0; gset = 1'b0; rdy4 = 1'b0; rdy5 = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            if (lpi_valid) begin
                pulses++; pk = k; gid = lpi_intid; gcpu = lpi_cpu; gset = lpi_set;
            end
            if (k == 4) rdy4 = msi_ready;
            if (k == 5) rdy5 = msi_ready;
            @(negedge clk);
        end
        if (ok) begin
            chk(pulses == 1 && pk == 4, "R11", {req, " pulse count/cycle"}, 32'(pulses * 16 + pk), 32'h14);
            chk(gid == eid && gcpu == ecpu && gset, req, "intid/cpu/set",
                {gid, 13'(gcpu), 3'(gset)}, {eid, 13'(ecpu), 3'd1});
            chk(!rdy4 && rdy5, "R12", "ready busy then free", {30'd0, rdy4, rdy5}, 32'd1);
        end else begin
            chk(pulses == 0, req, "dropped message made a pulse", 32'(pulses), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(msi_ready && !lpi_valid, "R1", "reset state", {30'd0, msi_ready, lpi_valid}, 32'd2);

        // R13 random table fill through the configuration port
        for (int i = 0; i < 256; i++)
            load(2'd0, i, {(($urandom % 4) != 0) ? 1'b1 : 1'b0, 7'($urandom % 7), 16'($urandom % 1100)});
        for (int i = 0; i < 1024; i++)
            load(2'd1, i, {8'($urandom % 20),
                           (($urandom % 5) == 0) ? 16'($urandom % 8192) : 16'(8192 + $urandom % 57000)});
        for (int i = 0; i < 16; i++)
            load(2'd2, i, 24'($urandom % 10));

        // Directed entries
        load(2'd0, 5, {1'b1, 7'd2, 16'd100});           // 8 events, base 100
        load(2'd0, 6, {1'b0, 7'd6, 16'd0});             // unmapped
        load(2'd1, 107, {8'd15, 16'd8192});
        load(2'd1, 103, {8'd0, 16'd8191});
        load(2'd1, 101, {8'd16, 16'd9000});
        load(2'd1, 102, {8'd3, 16'd9001});
        load(2'd1, 100, {8'd1, 16'd12345});
        load(2'd2, 15, 24'd7);
        load(2'd2, 3, 24'd8);
        load(2'd2, 1, 24'd2);

        // R2 disabled unit
        send(16'd5, GOOD, 32'd7, "R2");
        enable = 1'b1;
        send(16'd5, GOOD, 32'd7, "R9");                 // col 15, cpu 7, id 8192
        send(16'd5, GOOD, 32'd8, "R6");                 // event equals table size
        send(16'd5, GOOD, 32'd3, "R8");                 // id 8191
        send(16'd5, GOOD, 32'd1, "R9");                 // col 16
        send(16'd5, GOOD, 32'd2, "R10");                // cpu 8
        send(16'd5, GOOD, 32'd0, "R7");                 // base + 0
        send(16'd6, GOOD, 32'd0, "R5");
        send(16'd256, GOOD, 32'd7, "R4");
        send(16'd5, BASE + OFS, 32'd7, "R3");
        send(16'd5, GOOD + 32'd4, 32'd7, "R3");
        // R13 ignored writes: select 3 and out-of-range collection index
        cfg_write(2'd3, 16'd15, 24'd9);
        cfg_write(2'd2, 16'd31, 24'd9);
        send(16'd5, GOOD, 32'd7, "R13");
        enable = 1'b0;
        send(16'd5, GOOD, 32'd0, "R2");
        enable = 1'b1;

        // Random messages
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            a = (($urandom % 10) == 0) ? (BASE + OFS) : GOOD;
            send(16'($urandom % 280), a, 32'($urandom % 70), "R7");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule